// File: doc/BRIEF.md
# Warp Branch Divergence Sequencer

This block owns the lane enable mask of one 32-lane lockstep execution group. A launch sets the starting mask from a total thread count and the index of the group within the launch. Lane `i` is enabled when `warp*32 + i` is below the thread count, so the tail of the last group stays disabled. Every instruction is still issued to all lanes. Disabled lanes step through it, and the issue stage discards their results.

At a two-way branch the issue stage presents a per-lane condition vector. The block splits the current mask into a taken set (condition AND mask) and a fall-through set (NOT condition AND mask). It then issues the taken side first and the fall-through side second, each under its own mask. When the issue stage reports that the last side has finished, the block restores the exact pre-branch mask and pulses `done`. When every enabled lane agrees, only one pass is issued. The block handles a single level of branching and produces only masks and sequencing signals.

Top module: `warp_div_seq`

## Requirements
- R1: After reset, `lane_mask` is all zero, and `busy`, `done`, `path_sel` and `pass_cnt` are all 0.
- R2: When `launch` is accepted, the next cycle shows the new mask. Bit `i` of that mask is 1 exactly when `launch_warp*32 + i < launch_threads`. For example, 100 threads with group 3 gives 0x0000000F, and 64 threads with group 2 gives 0.
- R3: A branch whose taken set and fall-through set are both non-empty takes two passes.
  - First pass: `lane_mask` = cond & entry, `path_sel`=0, `pass_cnt`=1, `busy`=1.
  - After `path_end`: `lane_mask` = ~cond & entry, `path_sel`=1, `pass_cnt`=2.
- R4: A branch on which all enabled lanes agree takes a single pass with `pass_cnt`=1. If all enabled lanes are taken, `path_sel`=0. If none is taken, `path_sel`=1 and the mask is the full entry mask. The `path_end` of that single pass ends the branch.
- R5: On the `path_end` of the last pass, the next cycle shows the following:
  - `lane_mask` equals the pre-branch mask.
  - `pass_cnt`=0 and `path_sel`=0.
  - `done`=1 for that one cycle only, unless R7 applies.
- R6: While `busy`=1, `launch` is ignored. `br_valid` is also ignored while `busy`=1, except in the cycle described in R7. While `busy`=0, `path_end` is ignored.
- R7: A `br_valid` presented in the same cycle as the `path_end` of the last pass is accepted. Its split uses the restored mask. The next cycle shows `done`=1 together with the new branch's first pass, with `busy`=1.
- R8: When `busy`=0 and `launch` and `br_valid` are presented in the same cycle, the launch is taken and the branch is dropped.
- R9: `lane_mask` never enables a lane that is disabled in the mask set by the latest launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | Load a new starting mask |
| launch_threads | input | 11 | Total thread count of the launch (0 to 1024) |
| launch_warp | input | 5 | Index of this group within the launch |
| br_valid | input | 1 | Branch presented this cycle |
| br_cond | input | 32 | Per-lane branch condition, 1 = taken |
| path_end | input | 1 | Issue stage has finished the current pass |
| lane_mask | output | 32 | Current lane enable mask |
| path_sel | output | 1 | 0 = taken side issuing, 1 = fall-through side |
| pass_cnt | output | 2 | Pass number within the branch, 0 outside a branch |
| busy | output | 1 | A branch is in progress |
| done | output | 1 | One-cycle pulse: the branch reconverged |

## Verification
Reconvergence and the acceptance of a new branch can fall in the same cycle. The bench provokes this by raising `path_end` on the final pass of a single-pass branch together with `br_valid` and a fresh condition. It then expects, one cycle later, `done` high alongside `busy`, `pass_cnt`=1 and a mask split from the restored entry mask. A second collision comes from presenting `launch` and `br_valid` together while idle. That case is judged by the launch mask appearing with `busy` staying low, both in that cycle and in the cycle after.

// File: rtl/warp_div_pkg.sv
package warp_div_pkg;

    typedef enum logic [1:0] {
        ST_FLAT   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } seq_state_e;

endpackage

// File: rtl/warp_launch_mask.sv
module warp_launch_mask #(
    parameter int LANES       = 32,
    parameter int MAX_THREADS = 1024,
    localparam int TW = $clog2(MAX_THREADS + 1),
    localparam int WW = $clog2(MAX_THREADS / LANES),
    localparam int LW = $clog2(LANES)
) (
    input  logic [TW-1:0]    threads,
    input  logic [WW-1:0]    warp,
    output logic [LANES-1:0] mask
);
    logic [TW:0] base;
    logic [TW:0] limit;

    assign base  = {{(TW+1-WW){1'b0}}, warp} << LW;
    assign limit = {1'b0, threads};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [TW:0] OFF = (TW+1)'(i);
        assign mask[i] = (base + OFF) < limit;
    end
endmodule

// File: rtl/warp_branch_split.sv
module warp_branch_split #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] entry,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] taken,
    output logic [LANES-1:0] other,
    output logic             has_taken,
    output logic             has_other
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign taken[i] = entry[i] & cond[i];
        assign other[i] = entry[i] & ~cond[i];
    end
    assign has_taken = |taken;
    assign has_other = |other;
endmodule

// File: rtl/warp_div_seq.sv
module warp_div_seq
    import warp_div_pkg::*;
#(
    parameter int LANES       = 32,
    parameter int MAX_THREADS = 1024,
    localparam int TW = $clog2(MAX_THREADS + 1),
    localparam int WW = $clog2(MAX_THREADS / LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [TW-1:0]    launch_threads,
    input  logic [WW-1:0]    launch_warp,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_cond,
    input  logic             path_end,
    output logic [LANES-1:0] lane_mask,
    output logic             path_sel,
    output logic [1:0]       pass_cnt,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        seq_state_e       st;
        logic [LANES-1:0] entry;
        logic [LANES-1:0] mask;
        logic [LANES-1:0] pend;
        logic             sel;
        logic [1:0]       pass;
        logic             done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [LANES-1:0] lmask;
    logic [LANES-1:0] tk_mask, ot_mask;
    logic             has_tk, has_ot;

    warp_launch_mask #(.LANES(LANES), .MAX_THREADS(MAX_THREADS)) u_lmask (
        .threads (launch_threads),
        .warp    (launch_warp),
        .mask    (lmask)
    );

    warp_branch_split #(.LANES(LANES)) u_split (
        .entry     (seq_q.entry),
        .cond      (br_cond),
        .taken     (tk_mask),
        .other     (ot_mask),
        .has_taken (has_tk),
        .has_other (has_ot)
    );

    logic is_busy;
    assign is_busy = (seq_q.st != ST_FLAT);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (!is_busy) begin
            if (launch) begin
                seq_d.entry = lmask;
                seq_d.mask  = lmask;
            end else if (br_valid) begin
                seq_d.st   = ST_FIRST;
                seq_d.pass = 2'd1;
                if (has_tk) begin
                    seq_d.mask = tk_mask;
                    seq_d.sel  = 1'b0;
                    seq_d.pend = ot_mask;
                end else begin
                    seq_d.mask = ot_mask;
                    seq_d.sel  = 1'b1;
                    seq_d.pend = '0;
                end
            end
        end else if (path_end) begin
            if (seq_q.st == ST_FIRST && seq_q.pend != '0) begin
                seq_d.st   = ST_SECOND;
                seq_d.mask = seq_q.pend;
                seq_d.pend = '0;
                seq_d.sel  = 1'b1;
                seq_d.pass = 2'd2;
            end else begin
                seq_d.st   = ST_FLAT;
                seq_d.mask = seq_q.entry;
                seq_d.pend = '0;
                seq_d.sel  = 1'b0;
                seq_d.pass = 2'd0;
                seq_d.done = 1'b1;
                if (br_valid) begin
                    seq_d.st   = ST_FIRST;
                    seq_d.pass = 2'd1;
                    if (has_tk) begin
                        seq_d.mask = tk_mask;
                        seq_d.sel  = 1'b0;
                        seq_d.pend = ot_mask;
                    end else begin
                        seq_d.mask = ot_mask;
                        seq_d.sel  = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st    <= ST_FLAT;
            seq_q.entry <= '0;
            seq_q.mask  <= '0;
            seq_q.pend  <= '0;
            seq_q.sel   <= 1'b0;
            seq_q.pass  <= 2'd0;
            seq_q.done  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign lane_mask = seq_q.mask;
    assign path_sel  = seq_q.sel;
    assign pass_cnt  = seq_q.pass;
    assign busy      = is_busy;
    assign done      = seq_q.done;

    // R9: no lane outside the launch mask is ever enabled
    a_r9_within_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mask & ~seq_q.entry) == '0);

    // R3: second pass is the exact complement of the first within entry
    a_r3_second_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_cnt == 2'd2 && $past(pass_cnt) == 2'd1) |->
        ((lane_mask & $past(lane_mask)) == '0 &&
         (lane_mask | $past(lane_mask)) == seq_q.entry));

    // R5: a reconvergence with no new branch restores the entry mask
    a_r5_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !busy) |-> (lane_mask == seq_q.entry && pass_cnt == 2'd0));

    // R7: a done seen while busy belongs to a freshly started branch
    a_r7_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy) |-> (pass_cnt == 2'd1));

    // R6: idle with no request keeps the mask
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !launch && !br_valid) |=> $stable(lane_mask));

    // R2: a launch mask is contiguous from lane 0
    a_r2_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && launch) |=> ((lane_mask & (lane_mask + 1'b1)) == '0));
endmodule

// File: tb/warp_div_seq_tb.sv
`timescale 1ns/1ps
module warp_div_seq_tb;
    localparam int LANES = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch = 1'b0;
    logic [10:0] launch_threads = '0;
    logic [4:0]  launch_warp = '0;
    logic        br_valid = 1'b0;
    logic [31:0] br_cond = '0;
    logic        path_end = 1'b0;
    logic [31:0] lane_mask;
    logic        path_sel;
    logic [1:0]  pass_cnt;
    logic        busy;
    logic        done;

    always #4 clk = ~clk;

    warp_div_seq u_dut (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .launch_threads(launch_threads), .launch_warp(launch_warp),
        .br_valid(br_valid), .br_cond(br_cond), .path_end(path_end),
        .lane_mask(lane_mask), .path_sel(path_sel), .pass_cnt(pass_cnt),
        .busy(busy), .done(done)
    );

    typedef struct {
        logic [31:0] mask;
        logic        busy;
        logic        sel;
        logic [1:0]  pass;
        logic        done;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    function automatic logic [31:0] lmask(int threads, int warp);
        logic [31:0] m = '0;
        for (int i = 0; i < 32; i++) m[i] = (warp * 32 + i) < threads;
        return m;
    endfunction

    task automatic chk(string tag, string fld, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
        end
    endtask

    task automatic step(bit l, int thr, int wp, bit bv, logic [31:0] cond, bit pe,
                        logic [31:0] m, bit b, bit s, int p, bit d, string tag);
        exp_t e;
        @(negedge clk);
        launch = l; launch_threads = 11'(thr); launch_warp = 5'(wp);
        br_valid = bv; br_cond = cond; path_end = pe;
        e.mask = m; e.busy = b; e.sel = s; e.pass = 2'(p); e.done = d; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic nop(logic [31:0] m, bit b, bit s, int p, bit d, string tag);
        step(0, 0, 0, 0, 32'h0, 0, m, b, s, p, d, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                chk(e.tag, "lane_mask", lane_mask, e.mask);
                chk(e.tag, "busy", {31'b0, busy}, {31'b0, e.busy});
                chk(e.tag, "path_sel", {31'b0, path_sel}, {31'b0, e.sel});
                chk(e.tag, "pass_cnt", {30'b0, pass_cnt}, {30'b0, e.pass});
                chk(e.tag, "done", {31'b0, done}, {31'b0, e.done});
            end
        end
    end

    initial begin : watchdog
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "lane_mask", lane_mask, 32'h0);
        chk("R1", "busy", {31'b0, busy}, 32'h0);
        chk("R1", "done", {31'b0, done}, 32'h0);
        chk("R1", "pass_cnt", {30'b0, pass_cnt}, 32'h0);
        chk("R1", "path_sel", {31'b0, path_sel}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: launch masks, including boundary counts
        step(1, 100, 3, 0, 0, 0, 32'h0000000F, 0, 0, 0, 0, "R2 100thr w3");
        step(1, 100, 0, 0, 0, 0, lmask(100, 0), 0, 0, 0, 0, "R2 100thr w0");
        step(1, 64, 2, 0, 0, 0, 32'h0, 0, 0, 0, 0, "R2 64thr w2 empty");
        step(1, 31, 0, 0, 0, 0, 32'h7FFFFFFF, 0, 0, 0, 0, "R2 31thr");
        step(1, 1024, 31, 0, 0, 0, 32'hFFFFFFFF, 0, 0, 0, 0, "R2 1024thr w31");
        step(1, 48, 1, 0, 0, 0, lmask(48, 1), 0, 0, 0, 0, "R2 48thr w1");

        // R3: divergent branch, entry 0000FFFF
        step(0, 0, 0, 1, 32'h00FF00FF, 0, 32'h000000FF, 1, 0, 1, 0, "R3 first pass");
        // R6: launch while busy is ignored
        step(1, 1024, 0, 0, 0, 0, 32'h000000FF, 1, 0, 1, 0, "R6 launch ignored");
        step(0, 0, 0, 1, 32'hFFFFFFFF, 0, 32'h000000FF, 1, 0, 1, 0, "R6 branch ignored");
        step(0, 0, 0, 0, 0, 1, 32'h0000FF00, 1, 1, 2, 0, "R3 second pass");
        // R5: reconvergence
        step(0, 0, 0, 0, 0, 1, 32'h0000FFFF, 0, 0, 0, 1, "R5 restore");
        nop(32'h0000FFFF, 0, 0, 0, 0, "R5 done one cycle");
        // R6: path_end while idle is ignored
        step(0, 0, 0, 0, 0, 1, 32'h0000FFFF, 0, 0, 0, 0, "R6 idle path_end");

        // R4: uniform taken
        step(0, 0, 0, 1, 32'hFFFFFFFF, 0, 32'h0000FFFF, 1, 0, 1, 0, "R4 all taken");
        step(0, 0, 0, 0, 0, 1, 32'h0000FFFF, 0, 0, 0, 1, "R4 single pass end");
        // R4: uniform not taken
        step(0, 0, 0, 1, 32'hFFFF0000, 0, 32'h0000FFFF, 1, 1, 1, 0, "R4 none taken");
        // R7: final path_end with new branch same cycle
        step(0, 0, 0, 1, 32'h0000000F, 1, 32'h0000000F, 1, 0, 1, 1, "R7 back to back");
        step(0, 0, 0, 0, 0, 1, 32'h0000FFF0, 1, 1, 2, 0, "R7 second pass");
        step(0, 0, 0, 0, 0, 1, 32'h0000FFFF, 0, 0, 0, 1, "R7 reconverge");

        // R8: launch and branch together while idle
        step(1, 1024, 5, 1, 32'h00000001, 0, 32'hFFFFFFFF, 0, 0, 0, 0, "R8 launch wins");
        nop(32'hFFFFFFFF, 0, 0, 0, 0, "R8 branch dropped");

        // R9: lanes past the count stay off through a branch
        step(1, 5, 0, 0, 0, 0, 32'h0000001F, 0, 0, 0, 0, "R9 launch 5");
        step(0, 0, 0, 1, 32'hFFFFFFE0, 0, 32'h0000001F, 1, 1, 1, 0, "R9 tail lanes stay off");
        step(0, 0, 0, 0, 0, 1, 32'h0000001F, 0, 0, 0, 1, "R9 restore");
        step(0, 0, 0, 1, 32'hFFFFFFF5, 0, 32'h00000015, 1, 0, 1, 0, "R9 split first");
        step(0, 0, 0, 0, 0, 1, 32'h0000000A, 1, 1, 2, 0, "R9 split second");
        step(0, 0, 0, 0, 0, 1, 32'h0000001F, 0, 0, 0, 1, "R9 split end");
        nop(32'h0000001F, 0, 0, 0, 0, "R5 quiet");

        repeat (3) @(posedge clk);
        #3;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule